// File: doc/BRIEF.md
# Modulated Fractional Delay Line

This block is the delay element behind chorus and flanger effects. Every incoming audio sample goes into a circular store of 1024 words. In the same strobe the block reads one sample back from a distance that changes from sample to sample. That distance is formed as a mean delay plus a depth scaled by the current oscillator value. Because the distance is a fixed-point number, the output is a linear blend of the two stored neighbours that bracket it.

The caller presents four things on a one-cycle strobe: an input sample, a signed oscillator value, the mean delay and the depth. One cycle later the delayed, interpolated sample appears together with a one-cycle valid pulse. The delay is clamped so that both taps always point at samples that have already been written.

Top module: `mfd_delay_line`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_sample` is 0, and every buffer word reads as zero until it is written.
- R2: Each strobe on `in_valid` stores `in_sample` at the write position and moves that position on by exactly one. The position wraps from 1023 to 0, so a sample stays reachable for 1023 further strobes.
- R3: `out_valid` is high in exactly the cycle after each strobe and low otherwise.
- R4: The delay K, in samples, is unsigned Q10.12. It is computed as `mean_dly + floor(depth * lfo / 32768)`, where `mean_dly` and `depth` are unsigned Q10.12 and `lfo` is signed Q1.15 (two's complement).
- R5: When K is a whole number D, the output equals the sample stored D strobes before the current one.
- R6: When K = D + f/4096 with 0 < f < 4096, the output is floor((x0·(4096−f) + x1·f + 2048) / 4096). Here x0 is the sample stored D strobes back and x1 is the sample stored D+1 strobes back. The output is a 24-bit two's complement value.
- R7: A K below 1.0 is clamped to exactly 1.0, with a zero fraction.
- R8: A K above 1022.0 is clamped to exactly 1022.0, with a zero fraction.
- R9: In a cycle without a strobe, the buffer, the write position and `out_sample` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 24 | Input audio sample, signed |
| lfo | input | 16 | Oscillator value, signed Q1.15 |
| mean_dly | input | 22 | Mean delay, unsigned Q10.12 samples |
| depth | input | 22 | Modulation depth, unsigned Q10.12 samples |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_sample | output | 24 | Delayed, interpolated sample, signed |

## Verification
The hardest state to reach is a read whose two taps straddle the wrap point of the circular store while the delay sits at the upper clamp. That state needs more than a thousand stored samples with known values. The stimulus first streams over 1100 strobes of a pseudo-random sample pattern with short, varying whole-sample delays. It then walks the vector table, which pushes the delay to both clamps, to negative and full-scale oscillator values and to non-zero fractions. A bench-side model of the modulo store predicts every output.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  localparam int MFD_DATA_W = 24;
  localparam int MFD_ADDR_W = 10;
  localparam int MFD_FRAC_W = 12;
  localparam int MFD_LFO_W  = 16;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_LOW  = 2'd1,
    CLAMP_HIGH = 2'd2
  } clamp_e;
endpackage

// File: rtl/mfd_delay_calc.sv
module mfd_delay_calc
  import mfd_pkg::*;
#(
  parameter int ADDR_W = MFD_ADDR_W,
  parameter int FRAC_W = MFD_FRAC_W,
  parameter int LFO_W  = MFD_LFO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [LFO_W-1:0]  lfo,
  input  logic [ADDR_W+FRAC_W-1:0] mean_dly,
  input  logic [ADDR_W+FRAC_W-1:0] depth,
  output logic [ADDR_W-1:0]        tap_int,
  output logic [FRAC_W-1:0]        tap_frac,
  output clamp_e                   clamp_state
);
  localparam int KW = ADDR_W + FRAC_W;
  localparam int PW = KW + LFO_W + 1;
  localparam logic [KW-1:0] K_MIN = KW'(1) << FRAC_W;
  localparam logic [KW-1:0] K_MAX = KW'((1 << ADDR_W) - 2) << FRAC_W;
  localparam logic signed [PW-1:0] K_MIN_S = $signed({{(PW-KW){1'b0}}, K_MIN});
  localparam logic signed [PW-1:0] K_MAX_S = $signed({{(PW-KW){1'b0}}, K_MAX});

  // unclamped delay: mean + floor(depth * lfo / 2^(LFO_W-1))
  function automatic logic signed [PW-1:0] raw_delay(
    input logic signed [LFO_W-1:0] l,
    input logic [KW-1:0] m,
    input logic [KW-1:0] d
  );
    logic signed [PW-1:0] prod;
    prod = $signed({1'b0, d}) * l;
    return (prod >>> (LFO_W - 1)) + $signed({{(PW-KW){1'b0}}, m});
  endfunction

  logic signed [PW-1:0] k_raw;
  logic [KW-1:0]        k_used;

  always_comb begin
    k_raw = raw_delay(lfo, mean_dly, depth);
    if (k_raw < K_MIN_S) begin
      clamp_state = CLAMP_LOW;
      k_used      = K_MIN;
    end else if (k_raw > K_MAX_S) begin
      clamp_state = CLAMP_HIGH;
      k_used      = K_MAX;
    end else begin
      clamp_state = CLAMP_NONE;
      k_used      = k_raw[KW-1:0];
    end
  end

  assign tap_int  = k_used[KW-1:FRAC_W];
  assign tap_frac = k_used[FRAC_W-1:0];

  p_tap_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_int >= ADDR_W'(1)) && (tap_int <= ADDR_W'((1 << ADDR_W) - 2)));
  p_low_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_state == CLAMP_LOW) |-> (tap_int == ADDR_W'(1) && tap_frac == '0));
  p_high_exact_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_state == CLAMP_HIGH) |-> (tap_int == ADDR_W'((1 << ADDR_W) - 2) && tap_frac == '0));
endmodule

// File: rtl/mfd_ring_buf.sv
module mfd_ring_buf
  import mfd_pkg::*;
#(
  parameter int DATA_W = MFD_DATA_W,
  parameter int ADDR_W = MFD_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic signed [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        tap_dist,
  output logic signed [DATA_W-1:0] rd_near,
  output logic signed [DATA_W-1:0] rd_far
);
  localparam int DEPTH = 1 << ADDR_W;

  logic signed [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]        wr_ptr;
  logic [ADDR_W-1:0]        near_addr;
  logic [ADDR_W-1:0]        far_addr;

  // modulo arithmetic on ADDR_W bits gives the wrap for free
  assign near_addr = wr_ptr - tap_dist;
  assign far_addr  = near_addr - ADDR_W'(1);
  assign rd_near   = mem[near_addr];
  assign rd_far    = mem[far_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_ptr] <= wr_data;
      wr_ptr      <= wr_ptr + ADDR_W'(1);
    end
  end

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (wr_ptr == $past(wr_ptr) + ADDR_W'(1)));
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_ptr));
  p_taps_unwritten_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (near_addr != wr_ptr) && (far_addr != wr_ptr));
endmodule

// File: rtl/mfd_lerp.sv
module mfd_lerp
  import mfd_pkg::*;
#(
  parameter int DATA_W = MFD_DATA_W,
  parameter int FRAC_W = MFD_FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] near,
  input  logic signed [DATA_W-1:0] far,
  input  logic [FRAC_W-1:0]        frac,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  localparam int AW = DATA_W + FRAC_W + 2;
  localparam logic [FRAC_W:0]        ONE  = {1'b1, {FRAC_W{1'b0}}};
  localparam logic signed [AW-1:0]   HALF = AW'(1) <<< (FRAC_W - 1);

  // near*(1-f) + far*f, rounded half up to DATA_W bits
  function automatic logic signed [DATA_W-1:0] blend(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b,
    input logic [FRAC_W-1:0]        f
  );
    logic [FRAC_W:0]        wa;
    logic signed [AW-1:0]   acc;
    wa  = ONE - {1'b0, f};
    acc = AW'(a) * AW'($signed({1'b0, wa}))
        + AW'(b) * AW'($signed({1'b0, f}))
        + HALF;
    return DATA_W'(acc >>> FRAC_W);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= en;
      if (en) out_sample <= blend(near, far, frac);
    end
  end

  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> out_valid);
  p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid);
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(out_sample));
  p_between_taps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((out_sample >= $past(near) || out_sample >= $past(far)) &&
            (out_sample <= $past(near) || out_sample <= $past(far))));
endmodule

// File: rtl/mfd_delay_line.sv
module mfd_delay_line
  import mfd_pkg::*;
#(
  parameter int DATA_W = MFD_DATA_W,
  parameter int ADDR_W = MFD_ADDR_W,
  parameter int FRAC_W = MFD_FRAC_W,
  parameter int LFO_W  = MFD_LFO_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic signed [LFO_W-1:0]  lfo,
  input  logic [ADDR_W+FRAC_W-1:0] mean_dly,
  input  logic [ADDR_W+FRAC_W-1:0] depth,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_sample
);
  logic [ADDR_W-1:0]        tap_int;
  logic [FRAC_W-1:0]        tap_frac;
  clamp_e                   clamp_state;
  logic signed [DATA_W-1:0] tap_near;
  logic signed [DATA_W-1:0] tap_far;

  mfd_delay_calc #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .LFO_W(LFO_W)) u_calc (
    .clk         (clk),
    .rst_n       (rst_n),
    .lfo         (lfo),
    .mean_dly    (mean_dly),
    .depth       (depth),
    .tap_int     (tap_int),
    .tap_frac    (tap_frac),
    .clamp_state (clamp_state)
  );

  mfd_ring_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (in_valid),
    .wr_data  (in_sample),
    .tap_dist (tap_int),
    .rd_near  (tap_near),
    .rd_far   (tap_far)
  );

  mfd_lerp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_lerp (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (in_valid),
    .near       (tap_near),
    .far        (tap_far),
    .frac       (tap_frac),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );

  p_clamp_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_state != CLAMP_NONE) |-> (tap_frac == '0));
endmodule

// File: tb/tb_mfd_delay_line.sv
module tb_mfd_delay_line;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [23:0] in_sample = '0;
  logic signed [15:0] lfo = '0;
  logic [21:0]        mean_dly = '0;
  logic [21:0]        depth = '0;
  logic               out_valid;
  logic signed [23:0] out_sample;

  int total = 0;
  int bad = 0;
  longint mb [1024];
  longint wc = 0;

  mfd_delay_line dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .lfo(lfo), .mean_dly(mean_dly), .depth(depth),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  always #4 clk = ~clk;

  // vector table: oscillator, mean (Q10.12), depth (Q10.12), requirement
  localparam int NV = 12;
  localparam int V_LFO [NV] = '{0, 0, 16384, -16384, 32767, -32768, 0, 32767, 0, 1234, -20000, 0};
  localparam int V_MEAN [NV] = '{12288, 22528, 40960, 40960, 409600, 8192, 0,
                                 4096000, 4194303, 1228877, 2871200, 4186112};
  localparam int V_DEPTH [NV] = '{0, 0, 32768, 32768, 204800, 40960, 0,
                                  409600, 0, 12293, 819200, 0};
  localparam string V_REQ [NV] = '{"R5", "R6", "R4", "R4", "R4", "R7", "R7",
                                   "R8", "R8", "R6", "R4", "R2"};

  function automatic longint fdiv(input longint a, input longint b);
    longint q;
    q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint pat(input longint n);
    return ((n * 40503 + 17) % 16777216) - 8388608;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic strobe(input longint smp, input longint lv, input longint mv,
                        input longint dv, input string req);
    longint k, d, f, x0, x1, expv;
    k = mv + fdiv(dv * lv, 32768);
    if (k < 4096) k = 4096;
    if (k > 1022 * 4096) k = 1022 * 4096;
    d  = k / 4096;
    f  = k % 4096;
    x0 = mb[(wc - d) & 1023];
    x1 = mb[(wc - d - 1) & 1023];
    expv = fdiv(x0 * (4096 - f) + x1 * f + 2048, 4096);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 24'(smp);
    lfo       = 16'(lv);
    mean_dly  = 22'(mv);
    depth     = 22'(dv);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid after strobe (R3)", longint'(out_valid), 1);
    chk(req, "out_sample", longint'(out_sample), expv);
    mb[wc & 1023] = longint'($signed(24'(smp)));
    wc++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint held;
    for (int i = 0; i < 1024; i++) mb[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid in reset", longint'(out_valid), 0);
    chk("R1", "out_sample in reset", longint'(out_sample), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", longint'(out_valid), 0);
    // R1: unwritten words read as zero
    strobe(pat(0), 0, 5 * 4096, 0, "R1");
    strobe(pat(1), 0, 300 * 4096 + 1000, 0, "R1");

    // R2/R5: stream past the wrap with varying whole-sample delays
    for (int i = 2; i < 1102; i++) begin
      strobe(pat(i), 0, ((i % 9) + 1) * 4096, 0, "R5");
    end

    // vector table
    for (int v = 0; v < NV; v++) begin
      strobe(pat(wc), V_LFO[v], V_MEAN[v], V_DEPTH[v], V_REQ[v]);
    end

    // R9 and R3: no strobe, other inputs toggling
    held = longint'(out_sample);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_sample = 24'(pat(5000 + c));
      lfo       = 16'(c * 7000 - 20000);
      mean_dly  = 22'(c * 100000);
      depth     = 22'(c * 3333);
      @(negedge clk);
      chk("R3", "out_valid idle", longint'(out_valid), 0);
      chk("R9", "out_sample idle", longint'(out_sample), held);
    end
    // R9: buffer and write position untouched: delay 1 returns last stored sample
    strobe(pat(wc), 0, 4096, 0, "R9");
    strobe(pat(wc), 0, 2 * 4096 + 4095, 0, "R6");
    strobe(-8388608, 0, 4096 + 1, 0, "R6");
    strobe(8388607, 0, 4096 + 2048, 0, "R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule